// File: doc/BRIEF.md
# Truncated Squarer with Constant Correction

This block squares an unsigned operand and returns only the upper half of the square, rounded. The partial-product matrix is folded. Each cross term between two different operand bits appears once, at double weight. Each bit times itself reduces to the bit alone. A parameter sets how many of the lowest columns are never generated at all. The hardware then adds one fixed correction constant into the kept columns. This constant stands in for the average value of the columns that were cut away, plus half an output step so that the result is rounded. The cost is a bounded error that is not symmetric about zero. The benefit is a smaller adder array.

The correction constant is a parameter expressed in units of the lowest kept column. It can be chosen automatically: the expected sum of the removed bits, plus half an output ulp, rounded to the kept-column grid. When the corrected sum does not fit, the output clamps at all ones. The result can be taken straight from the logic or through one output register. That register has an asynchronous active-low reset.

Top module: `trunc_squarer`

## Requirements
- R1: While `rst_n` is low, the registered variant (REG_OUT=1) drives `sq_o` to zero, whatever the operand.
- R2: In the registered variant, `sq_o` shows the result for the operand present at the previous rising edge of `clk`. It keeps its old value until that edge.
- R3: With DROP_COLS=0 and CORR=2^(WIDTH-1), the result equals floor((x² + 2^(WIDTH-1)) / 2^WIDTH) for every operand. This is exact round-half-up of the upper half.
- R4: The output equals floor((K + C) / 2^WIDTH). K is the sum of all folded partial-product bits in columns at or above DROP_COLS. C = CORR·2^DROP_COLS. Cross term x_i·x_j (i<j) sits in column i+j+1, and diagonal x_i sits in column 2i. Therefore x²+C−Dmax < (out+1)·2^WIDTH and out·2^WIDTH ≤ x²+C, where Dmax is the sum of every bit position in the dropped columns. The default (WIDTH=16, DROP_COLS=12) gives CORR=9, C=36864 and Dmax=20481. Its error against the exact square therefore stays within −0.75 to +0.5625 ulp.
- R5: In the default configuration, no output differs from round-to-nearest of x²/2^16 by more than one ulp.
- R6: When x²+C is at least 2^(2·WIDTH)+Dmax, the output is all ones instead of a wrapped value. Example: WIDTH=8, DROP_COLS=4, CORR=64 and x=255 give 255.
- R7: A zero operand yields floor(C/2^WIDTH). This is 0 for the default configuration and 4 for WIDTH=8, DROP_COLS=4, CORR=64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_i | input | WIDTH | Unsigned operand |
| sq_o | output | WIDTH | Upper half of the corrected square, saturating |

## Verification
The 16-bit configuration is swept over all 65536 operands. For each one, the error against the exact square is checked against the analytic window, the result is compared with a round-to-nearest reference, and the minimum, maximum and mean error are reported. Some operands have their low bits clear, so no matrix bit is lost; these show whether the correction constant and the folded weights land in the right columns. The all-ones and low-byte-only operands drop the greatest share of the matrix, which tests the negative edge of the window. An uncut instance with half-ulp correction is compared exactly with true rounding across the same sweep. A small 8-bit instance with an oversized constant separates clamping from wraparound.

// File: rtl/trunc_squarer.sv
module trunc_squarer #(
  parameter int WIDTH     = 16,
  parameter int DROP_COLS = WIDTH - 4,
  parameter int CORR      = -1,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] sq_o
);
  localparam int PW = 2*WIDTH + 1;

  // expected value of the removed columns in quarter units, plus half an output ulp
  function automatic longint unsigned auto_corr();
    longint unsigned q;
    q = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (2*i < DROP_COLS) q = q + (64'd2 << (2*i));
      for (int j = i + 1; j < WIDTH; j++)
        if (i + j + 1 < DROP_COLS) q = q + (64'd1 << (i + j + 1));
    end
    return (q + (64'd4 << (WIDTH - 1)) + (64'd2 << DROP_COLS)) >> (DROP_COLS + 2);
  endfunction

  localparam longint unsigned CORR_U = (CORR < 0) ? auto_corr() : longint'(CORR);
  localparam logic [PW-1:0]   C_EFF  = PW'(CORR_U << DROP_COLS);

  logic [PW-1:0]    acc;
  logic [WIDTH-1:0] sq_next;

  always_comb begin
    acc = C_EFF;
    for (int i = 0; i < WIDTH; i++) begin
      if (2*i >= DROP_COLS) acc = acc + (PW'(x_i[i]) << (2*i));
      for (int j = i + 1; j < WIDTH; j++)
        if (i + j + 1 >= DROP_COLS) acc = acc + (PW'(x_i[i] & x_i[j]) << (i + j + 1));
    end
  end

  assign sq_next = acc[PW-1] ? '1 : acc[PW-2:WIDTH];

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sq_o <= '0;
        else        sq_o <= sq_next;
    end else begin : g_comb
      assign sq_o = sq_next;
    end
  endgenerate
endmodule

// File: rtl/trunc_squarer_chk.sv
module trunc_squarer_chk #(
  parameter int              WIDTH     = 16,
  parameter int              DROP_COLS = 12,
  parameter longint unsigned CORR_U    = 9,
  parameter bit              REG_OUT   = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] sq_next,
  input logic [WIDTH-1:0] sq_o
);
  localparam int W2 = 2*WIDTH + 2;

  function automatic longint unsigned drop_max();
    longint unsigned s;
    s = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (2*i < DROP_COLS) s = s + (64'd1 << (2*i));
      for (int j = i + 1; j < WIDTH; j++)
        if (i + j + 1 < DROP_COLS) s = s + (64'd1 << (i + j + 1));
    end
    return s;
  endfunction

  localparam logic [W2-1:0] CW   = W2'(CORR_U << DROP_COLS);
  localparam logic [W2-1:0] DMAX = W2'(drop_max());
  localparam logic [W2-1:0] MAXV = W2'({WIDTH{1'b1}});
  localparam logic [W2-1:0] OVF  = (W2'(1) << (2*WIDTH)) + DMAX;

  logic [W2-1:0] tgt, up_side, lo_side, rnd;
  always_comb begin
    tgt     = W2'(x_i) * W2'(x_i) + CW;
    up_side = W2'(sq_next) << WIDTH;
    lo_side = ((W2'(sq_next) + W2'(1)) << WIDTH) + DMAX;
    rnd     = ((tgt >> WIDTH) > MAXV) ? MAXV : (tgt >> WIDTH);
  end

  a_r4_upper_bound: assert property (@(posedge clk) disable iff (!rst_n)
    up_side <= tgt);
  a_r4_lower_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_next != WIDTH'(MAXV)) |-> (lo_side > tgt));
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt >= OVF) |-> (sq_next == WIDTH'(MAXV)));

  generate
    if (REG_OUT) begin : g_reg_chk
      a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |-> (sq_o == '0));
      a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sq_o == $past(sq_next)));
    end else begin : g_comb_chk
      a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        sq_o == sq_next);
    end
    if (DROP_COLS == 0) begin : g_exact_chk
      a_r3_exact: assert property (@(posedge clk) disable iff (!rst_n)
        W2'(sq_next) == rnd);
    end
  endgenerate
endmodule

bind trunc_squarer trunc_squarer_chk #(
  .WIDTH(WIDTH), .DROP_COLS(DROP_COLS), .CORR_U(CORR_U), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .x_i(x_i), .sq_next(sq_next), .sq_o(sq_o)
);

// File: tb/trunc_squarer_tb.sv
`timescale 1ns/1ps
module trunc_squarer_tb;
  localparam longint C_DEF = 36864;          // 9 * 2^12
  localparam longint D_DEF = 20481;          // all bit positions in columns 0..11
  localparam longint E_HI  = C_DEF;
  localparam longint E_LO  = C_DEF - D_DEF - 65536 + 1;

  // {operand, expected output} for the default instance
  localparam logic [31:0] VEC [10] = '{
    {16'h0000, 16'h0000}, {16'h0003, 16'h0000}, {16'h0100, 16'h0001},
    {16'h0800, 16'h0040}, {16'h1000, 16'h0100}, {16'h8000, 16'h4000},
    {16'hFF00, 16'hFE01}, {16'h00FF, 16'h0001}, {16'hFFFF, 16'hFFFE},
    {16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] x_d, x_e, q_d, q_e;
  logic [7:0]  x_s, q_s;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trunc_squarer u_dut (.clk(clk), .rst_n(rst_n), .x_i(x_d), .sq_o(q_d));
  trunc_squarer #(.WIDTH(16), .DROP_COLS(0), .CORR(32768), .REG_OUT(1'b0))
    u_dut_exact (.clk(clk), .rst_n(rst_n), .x_i(x_e), .sq_o(q_e));
  trunc_squarer #(.WIDTH(8), .DROP_COLS(4), .CORR(64), .REG_OUT(1'b0))
    u_dut_sat (.clk(clk), .rst_n(rst_n), .x_i(x_s), .sq_o(q_s));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    longint sq, err, emin, emax, esum, rnd;
    rst_n = 1'b0;
    x_d = 16'hFFFF; x_e = 16'h0; x_s = 8'h0;
    repeat (3) @(posedge clk);
    #2 chk(q_d == 16'h0, "R1 held in reset", q_d, 0);
    @(negedge clk) rst_n = 1'b1;

    // table walk
    for (int k = 0; k < 10; k++) begin
      @(negedge clk) x_d = VEC[k][31:16];
      @(posedge clk) #2;
      chk(q_d == VEC[k][15:0], "R4 vector", q_d, VEC[k][15:0]);
    end
    chk(q_d == 16'h0, "R7 zero operand", q_d, 0);

    // latency
    @(negedge clk) x_d = 16'h1000;
    @(posedge clk) #2 chk(q_d == 16'h0100, "R2 first value", q_d, 256);
    @(negedge clk) x_d = 16'h8000;
    #1 chk(q_d == 16'h0100, "R2 holds before edge", q_d, 256);
    @(posedge clk) #2 chk(q_d == 16'h4000, "R2 after edge", q_d, 16384);

    // asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1 chk(q_d == 16'h0, "R1 async clear", q_d, 0);
    @(negedge clk) rst_n = 1'b1;

    // saturation instance
    x_s = 8'd0;   #1 chk(q_s == 8'd4,   "R7 zero operand narrow", q_s, 4);
    x_s = 8'h80;  #1 chk(q_s == 8'd68,  "R4 narrow no drop", q_s, 68);
    x_s = 8'hF0;  #1 chk(q_s == 8'd229, "R4 narrow high bits", q_s, 229);
    x_s = 8'hFF;  #1 chk(q_s == 8'd255, "R6 clamps", q_s, 255);

    // exhaustive sweep
    emin = 64'sd1 << 40; emax = -(64'sd1 << 40); esum = 0;
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk) begin x_d = 16'(v); x_e = 16'(v); end
      @(posedge clk) #2;
      sq  = longint'(v) * longint'(v);
      rnd = (sq + 32768) >>> 16;
      err = (longint'(q_d) <<< 16) - sq;
      if (err < emin) emin = err;
      if (err > emax) emax = err;
      esum += err;
      chk(err >= E_LO && err <= E_HI, "R4 error window", err, E_HI);
      chk((longint'(q_d) - rnd) <= 1 && (rnd - longint'(q_d)) <= 1,
          "R5 within one ulp of nearest", q_d, rnd);
      chk(longint'(q_e) == rnd, "R3 exact rounding", q_e, rnd);
    end
    $display("error ulp: min %f max %f mean %f",
             real'(emin) / 65536.0, real'(emax) / 65536.0,
             real'(esum) / 65536.0 / 65536.0);
    chk(emin >= E_LO, "R4 sweep minimum", emin, E_LO);
    chk(emax <= E_HI, "R4 sweep maximum", emax, E_HI);
    done = 1'b1;
    summary();
  end
endmodule